// File: doc/BRIEF.md
# Integer ALU with Signed Set-on-Compare

This block is the integer execute unit of a 32-bit load/store core. Each cycle it takes two operands and a 6-bit operation code, which is the function field of a register-register instruction. It returns one word, registered at the next rising clock edge.

The operations are:
- wrapping add and subtract;
- bitwise AND, OR and XOR;
- shift left, logical shift right and arithmetic shift right. The shift count is always the low five bits of the second operand.
- six signed comparisons, each producing the value 0 or 1.

A code that names none of these yields a zero result and raises a flag, so the surrounding pipeline can raise an exception.

Instruction decoding, the register file, memory access and overflow trapping belong to neighbouring blocks. The ALU sees only operands and the function code.

Top module: `alu_core`

## Requirements
- R1: Code 100000 gives op_a + op_b modulo 2^32, with no overflow indication.
- R2: Code 100010 gives op_a - op_b modulo 2^32, with no overflow indication.
- R3: Codes 100100, 100101 and 100110 give bitwise AND, OR and XOR of the operands.
- R4: Code 000100 shifts op_a left by op_b[4:0] and fills with zeros; op_b[31:5] has no effect on any shift.
- R5: Code 000110 shifts op_a right by op_b[4:0] and fills with zeros.
- R6: Code 000111 shifts op_a right by op_b[4:0] and fills with copies of op_a[31].
- R7: Code 101010 yields 1 when op_a < op_b. Code 101100 yields 1 when op_a <= op_b. Both treat the operands as signed two's complement and yield 0 otherwise.
- R8: Code 101011 yields 1 when op_a > op_b. Code 101101 yields 1 when op_a >= op_b. Both compare signed and yield 0 otherwise.
- R9: Code 101000 yields 1 when the operands are equal. Code 101001 yields 1 when they differ.
- R10: Every compare result has bits [31:1] equal to zero.
- R11: Any other code gives result 0 with illegal = 1. Every listed code gives illegal = 0.
- R12: result and illegal are registered: they reflect the inputs present at the previous rising clock edge. An active-low asynchronous reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; bits [4:0] are the shift count |
| func | input | 6 | Operation code |
| result | output | 32 | Registered result |
| illegal | output | 1 | Registered flag for an unrecognised code |

## Verification
The bench drives every legal code against every pair from a set of corner operands: zero, one, minus one, the most positive value, the most negative value, and two mixed patterns.
- A comparison done unsigned would invert the order between the most negative value and small positives.
- An add or subtract that is not wrapping would disagree at the signed extremes.
- Shifts are swept over all 32 counts with junk in op_b[31:5]. A shifter that looks at bits above [4:0] would shift by the wrong count. A shifter with the wrong fill would show the wrong top bits.

All 64 codes are also swept, so a code that is missing from the legal set, or decoded into it by mistake, shows up as a wrong illegal flag or a nonzero result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FN_W = 6;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_XOR = 6'b100110;
    localparam logic [FN_W-1:0] FN_SLL = 6'b000100;
    localparam logic [FN_W-1:0] FN_SRL = 6'b000110;
    localparam logic [FN_W-1:0] FN_SRA = 6'b000111;
    localparam logic [FN_W-1:0] FN_SEQ = 6'b101000;
    localparam logic [FN_W-1:0] FN_SNE = 6'b101001;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;
    localparam logic [FN_W-1:0] FN_SGT = 6'b101011;
    localparam logic [FN_W-1:0] FN_SLE = 6'b101100;
    localparam logic [FN_W-1:0] FN_SGE = 6'b101101;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    input  shift_kind_t    kind,
    output logic [W-1:0]   y
);
    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    logic         fill;
    logic [W-1:0] stg [0:SHW];

    assign fill   = (kind == SH_RARI) & a[W-1];
    assign stg[0] = (kind == SH_LEFT) ? flip(a) : a;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stg[i+1] = amt[i] ? {{STEP{fill}}, stg[i][W-1:STEP]} : stg[i];
    end

    assign y = (kind == SH_LEFT) ? flip(stg[SHW]) : stg[SHW];
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt,
    output logic         eq
);
    always_comb begin
        eq = (a == b);
        if (a[W-1] != b[W-1]) lt = a[W-1];
        else                  lt = (a[W-2:0] < b[W-2:0]);
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [5:0]    func,
    output logic [W-1:0]  result,
    output logic          illegal
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         bad;
    } out_t;

    out_t        out_d, out_q;
    logic        sub_sel;
    shift_kind_t sh_kind;
    logic [W-1:0] sum_w, shf_w;
    logic        lt_w, eq_w;

    always_comb begin
        sub_sel = (func == FN_SUB);
        unique case (func)
            FN_SRL:  sh_kind = SH_RLOG;
            FN_SRA:  sh_kind = SH_RARI;
            default: sh_kind = SH_LEFT;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a   (op_a),
        .b   (op_b),
        .sub (sub_sel),
        .sum (sum_w)
    );

    alu_shifter #(.W(W), .SHW(SHW)) u_shift (
        .a    (op_a),
        .amt  (op_b[SHW-1:0]),
        .kind (sh_kind),
        .y    (shf_w)
    );

    alu_compare #(.W(W)) u_cmp (
        .a  (op_a),
        .b  (op_b),
        .lt (lt_w),
        .eq (eq_w)
    );

    function automatic logic [W-1:0] as_word(input logic bit_v);
        return {{(W-1){1'b0}}, bit_v};
    endfunction

    always_comb begin
        out_d.res = '0;
        out_d.bad = 1'b0;
        case (func)
            FN_ADD, FN_SUB:         out_d.res = sum_w;
            FN_AND:                 out_d.res = op_a & op_b;
            FN_OR:                  out_d.res = op_a | op_b;
            FN_XOR:                 out_d.res = op_a ^ op_b;
            FN_SLL, FN_SRL, FN_SRA: out_d.res = shf_w;
            FN_SEQ:                 out_d.res = as_word(eq_w);
            FN_SNE:                 out_d.res = as_word(~eq_w);
            FN_SLT:                 out_d.res = as_word(lt_w);
            FN_SLE:                 out_d.res = as_word(lt_w | eq_w);
            FN_SGT:                 out_d.res = as_word(~(lt_w | eq_w));
            FN_SGE:                 out_d.res = as_word(~lt_w);
            default:                out_d.bad = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result  = out_q.res;
    assign illegal = out_q.bad;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [5:0]   func,
    input logic [W-1:0] result,
    input logic         illegal
);
    logic fn_cmp;
    assign fn_cmp = (func[5:3] == 3'b101) && (func[2:0] <= 3'd5);

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0)); // R11

    AST_ADD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 6'b100000) |=> !illegal); // R11

    AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 6'b100000) |=> (result == $past(op_a) + $past(op_b))); // R1

    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        fn_cmp |=> (result[W-1:1] == '0)); // R10

    AST_SEQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 6'b101000) |=> (result[0] == ($past(op_a) == $past(op_b)))); // R9

    AST_SRA_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 6'b000111 && op_a[W-1]) |=> result[W-1]); // R6

    AST_SRL_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 6'b000110 && op_b[4:0] != 5'd0) |=> !result[W-1]); // R5
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .func    (func),
    .result  (result),
    .illegal (illegal)
);

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [5:0]  func = '0;
    logic [31:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    alu_core u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .func(func), .result(result), .illegal(illegal)
    );

    function automatic string req_of(input logic [5:0] f);
        case (f)
            6'b100000: return "R1";
            6'b100010: return "R2";
            6'b100100, 6'b100101, 6'b100110: return "R3";
            6'b000100: return "R4";
            6'b000110: return "R5";
            6'b000111: return "R6";
            6'b101010, 6'b101100: return "R7";
            6'b101011, 6'b101101: return "R8";
            6'b101000, 6'b101001: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [5:0] f,
                         output logic [31:0] r, output logic bad);
        int sa, sb;
        int unsigned n;
        sa = a; sb = b; n = b & 32'h1f; bad = 0;
        case (f)
            6'b100000: r = a + b;
            6'b100010: r = a - b;
            6'b100100: r = a & b;
            6'b100101: r = a | b;
            6'b100110: r = a ^ b;
            6'b000100: r = a << n;
            6'b000110: r = a >> n;
            6'b000111: r = sa >>> n;
            6'b101000: r = (a == b) ? 1 : 0;
            6'b101001: r = (a != b) ? 1 : 0;
            6'b101010: r = (sa <  sb) ? 1 : 0;
            6'b101011: r = (sa >  sb) ? 1 : 0;
            6'b101100: r = (sa <= sb) ? 1 : 0;
            6'b101101: r = (sa >= sb) ? 1 : 0;
            default: begin r = 0; bad = 1; end
        endcase
    endtask

    task automatic check(input string req, input logic [31:0] got_r, input logic got_b,
                         input logic [31:0] exp_r, input logic exp_b);
        checks++;
        if (got_r !== exp_r || got_b !== exp_b) begin
            errors++;
            $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                     req, got_r, got_b, exp_r, exp_b);
        end
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [5:0] f);
        logic [31:0] er;
        logic eb;
        model(a, b, f, er, eb);
        @(negedge clk);
        op_a = a; op_b = b; func = f;
        @(posedge clk);
        #1;
        check(req_of(f), result, illegal, er, eb);
        if (f[5:3] == 3'b101 && f[2:0] <= 3'd5 && result[31:1] !== 31'd0) begin
            checks++; errors++;
            $display("FAIL R10: upper bits=%h expected 0", result[31:1]);
        end
    endtask

    logic [31:0] corner [0:7];
    logic [5:0]  legal  [0:13];

    initial begin
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h8000_0000; corner[5] = 32'h8000_0001;
        corner[6] = 32'h5A5A_A5A5; corner[7] = 32'h0000_0020;
        legal[0] = 6'b100000; legal[1] = 6'b100010; legal[2] = 6'b100100;
        legal[3] = 6'b100101; legal[4] = 6'b100110; legal[5] = 6'b000100;
        legal[6] = 6'b000110; legal[7] = 6'b000111; legal[8] = 6'b101000;
        legal[9] = 6'b101001; legal[10] = 6'b101010; legal[11] = 6'b101011;
        legal[12] = 6'b101100; legal[13] = 6'b101101;

        op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678; func = 6'b100000;
        repeat (3) @(posedge clk);
        #1;
        check("R12 reset", result, illegal, 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int fi = 0; fi < 14; fi++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run(corner[i], corner[j], legal[fi]);

        // R4 R5 R6: every count, junk above bit 4 of op_b
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < 32; n++) begin
                run(32'h8765_4321, 32'hFFFF_FFE0 | n, legal[5 + k]);
                run(32'h0F0F_00F1, 32'hABCD_0060 | n, legal[5 + k]);
            end

        // R11: every possible code
        for (int f = 0; f < 64; f++) run(32'h1357_9BDF, 32'h0000_0003, f[5:0]);

        for (int r = 0; r < 1500; r++)
            run($urandom, $urandom, legal[$urandom_range(0, 13)]);

        // R12: output holds until the next edge
        run(32'd5, 32'd7, 6'b100000);
        @(negedge clk);
        op_a = 32'd100; op_b = 32'd1; func = 6'b100010;
        #1;
        check("R12 hold", result, illegal, 32'd12, 1'b0);
        @(posedge clk);
        #1;
        check("R12 update", result, illegal, 32'd99, 1'b0);

        // R12: asynchronous reset clears outputs
        @(negedge clk);
        func = 6'b111111;
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check("R12 async reset", result, illegal, 32'h0, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule